// File: doc/BRIEF.md
# Programmable-Modulus Cascaded Sigma-Delta Divide Controller

This block produces the instantaneous divide value for a fractional-N feedback divider, one new value per reference-rate clock. Software supplies an integer divide value, a fractional numerator, a fractional denominator and a noise-shaping order. The block runs a cascade of up to four accumulators. Each accumulator wraps at the programmed denominator, not at a power of two, so exact ratios such as 1/3 or 7/1000 can be set. Over time the output settles on integer + numerator/denominator.

The carries of the active stages are combined through the usual cascaded differencing network, and the signed correction is added to the integer value. Order 0 gives a plain integer divider. A sync strobe returns every accumulator and every history register to zero, so that the output sequence repeats exactly after each sync. A one-shot phase strobe adds a programmed offset into the first accumulator, which shifts the output phase in fractions of one denominator step.

Top module: `mash_divctl`

## Requirements
- R1: While rst_n is low and on the first cycle after its release, div_o is 0. The held configuration resets to integer 0, numerator 0, denominator 1 and order 0.
- R2: int_i, num_i, den_i and order_i are captured together only on a clock edge where load_i is high; at any other edge these pins have no effect. On capture, a denominator of 0 is stored as 1, a numerator at or above the stored denominator is stored as denominator−1, and an order above 4 is stored as 4. The same edge clears all accumulators and history registers, and div_o takes the integer value held before that edge.
- R3: With stored order 0, div_o equals the stored integer every cycle, whatever the numerator and phase inputs are.
- R4: Each active stage k (k < order) forms acc + input. If the sum is at or above the denominator, the stage subtracts the denominator and sets carry ck = 1. Otherwise ck = 0. Stage 1 takes the numerator as its input. Stage k+1 takes stage k's new residue from the same cycle. Inactive stages hold 0 and produce no carry.
- R5: The correction is c1 for order 1. Order 2 adds (c2 − c2'). Order 3 further adds (c3 − 2c3' + c3''). Order 4 further adds (c4 − 3c4' + 3c4'' − c4'''). A prime marks a value from one edge earlier. div_o after an edge equals the stored integer plus the correction formed from that edge's carries.
- R6: div_o minus the stored integer always lies in −7 to +8.
- R7: A clock edge with sync_i high clears all accumulators and history registers and loads div_o with the stored integer. The output sequence that follows two such syncs under the same configuration is identical.
- R8: On an edge with phase_i high, order ≥ 1, and neither sync_i nor load_i high, phase_ofs_i is clamped to denominator−1. It is added to the first accumulator and reduced modulo the denominator, discarding that wrap's carry, before the numerator is added. The strobe acts on that edge only.
- R9: Sum the values (div_o − integer) over the denominator cycles that follow a load. At order 1 this sum equals the stored numerator exactly. At orders 2 to 4 it lies within −3 to +4 of the numerator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Capture strobe for the four configuration inputs |
| int_i | input | 19 | Integer divide value |
| num_i | input | 32 | Fractional numerator |
| den_i | input | 32 | Fractional denominator (modulus) |
| order_i | input | 3 | Noise-shaping order, 0 to 4 |
| sync_i | input | 1 | Clears accumulator and history state |
| phase_i | input | 1 | One-shot phase offset strobe |
| phase_ofs_i | input | 32 | Offset added into the first accumulator |
| div_o | output | 20 | Instantaneous divide value |

## Verification
Every numerator below each of a set of small denominators, from 1 up to 16, is run at all five orders. A cycle-exact arithmetic model in the bench separates wrap-at-modulus errors from faults in the differencing polynomial and in the order gating. Over each denominator window, the correction sum is checked against the numerator; this exposes a carry that is lost or counted twice. A denominator near 2^32 with an extreme numerator tests the carry bit of the adder and the full −7..+8 correction swing. Out-of-range loads, pin changes without a load, sync replay and repeated or clamped phase strobes each have their own checks.

// File: rtl/mash_pkg.sv
// Shared constants and types for the cascaded sigma-delta divide controller.
// Assumes at most four accumulator stages; the correction type is sized for
// the order-4 swing of -7..+8.
package mash_pkg;
    localparam int MAX_ORDER = 4;
    localparam int CORR_W    = 5;

    typedef logic signed [CORR_W-1:0] corr_t;
endpackage

// File: rtl/mash_cfg_reg.sv
// Configuration holding register. Captures integer, numerator, denominator
// and order together on load_i, and sanitises them so that later logic can
// assume den >= 1, num < den and order <= MAX_ORDER.
module mash_cfg_reg
    import mash_pkg::*;
#(
    parameter int INT_W  = 19,
    parameter int FRAC_W = 32,
    parameter int ORD_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [INT_W-1:0]  int_i,
    input  logic [FRAC_W-1:0] num_i,
    input  logic [FRAC_W-1:0] den_i,
    input  logic [ORD_W-1:0]  order_i,
    output logic [INT_W-1:0]  int_q,
    output logic [FRAC_W-1:0] num_q,
    output logic [FRAC_W-1:0] den_q,
    output logic [ORD_W-1:0]  order_q
);
    logic [FRAC_W-1:0] den_c;
    logic [FRAC_W-1:0] num_c;
    logic [ORD_W-1:0]  ord_c;

    // Clamp incoming values into the legal operating range.
    always_comb begin
        den_c = (den_i == '0) ? FRAC_W'(1) : den_i;
        num_c = (num_i >= den_c) ? den_c - FRAC_W'(1) : num_i;
        ord_c = (order_i > ORD_W'(MAX_ORDER)) ? ORD_W'(MAX_ORDER) : order_i;
    end

    // Hold the configuration; update all fields at once on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q   <= '0;
            num_q   <= '0;
            den_q   <= FRAC_W'(1);
            order_q <= '0;
        end else if (load_i) begin
            int_q   <= int_i;
            num_q   <= num_c;
            den_q   <= den_c;
            order_q <= ord_c;
        end
    end
endmodule

// File: rtl/mash_acc_stage.sv
// One modulo-den accumulator stage. Optionally pre-adds a clamped offset
// (reduced once modulo den, carry discarded) before adding its input.
// Assumes acc_q < den_i and in_i < den_i, so a single subtraction suffices.
// When disabled it outputs zero residue, no carry, and clears its state.
module mash_acc_stage #(
    parameter int FRAC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic [FRAC_W-1:0] den_i,
    input  logic [FRAC_W-1:0] in_i,
    input  logic              ofs_en_i,
    input  logic [FRAC_W-1:0] ofs_i,
    output logic [FRAC_W-1:0] res_o,
    output logic              carry_o,
    output logic [FRAC_W-1:0] acc_o
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W-1:0] ofs_c;
    logic [FRAC_W-1:0] base;
    logic [FRAC_W:0]   pre;
    logic [FRAC_W:0]   sum_w;

    // Offset pre-add, then main modulo add with carry detection.
    always_comb begin
        ofs_c = (ofs_i >= den_i) ? den_i - FRAC_W'(1) : ofs_i;
        pre   = {1'b0, acc_q} + {1'b0, ofs_c};
        if (!ofs_en_i) begin
            base = acc_q;
        end else if (pre >= {1'b0, den_i}) begin
            base = FRAC_W'(pre - {1'b0, den_i});
        end else begin
            base = pre[FRAC_W-1:0];
        end
        sum_w = {1'b0, base} + {1'b0, in_i};
        if (!en_i) begin
            carry_o = 1'b0;
            res_o   = '0;
        end else if (sum_w >= {1'b0, den_i}) begin
            carry_o = 1'b1;
            res_o   = FRAC_W'(sum_w - {1'b0, den_i});
        end else begin
            carry_o = 1'b0;
            res_o   = sum_w[FRAC_W-1:0];
        end
    end

    // Residue register, cleared by reset, sync or load.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            acc_q <= '0;
        end else begin
            acc_q <= res_o;
        end
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/mash_noise_shaper.sv
// Differencing network for the cascaded modulator. Keeps carry history for
// stages 2..4 and forms the signed correction for the selected order.
// Assumes carries of inactive stages are already zero.
module mash_noise_shaper
    import mash_pkg::*;
#(
    parameter int ORD_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic [ORD_W-1:0]     order_i,
    input  logic [MAX_ORDER-1:0] carry_i,
    output corr_t                corr_o
);
    logic h2;
    logic h3a, h3b;
    logic h4a, h4b, h4c;
    corr_t t1, t2, t3, t4;

    function automatic corr_t ext(input logic b);
        return b ? corr_t'(1) : corr_t'(0);
    endfunction

    // Form each stage's differenced term and sum those the order enables.
    always_comb begin
        t1 = ext(carry_i[0]);
        t2 = ext(carry_i[1]) - ext(h2);
        t3 = ext(carry_i[2]) - ext(h3a) - ext(h3a) + ext(h3b);
        t4 = ext(carry_i[3]) - ext(h4a) - ext(h4a) - ext(h4a)
             + ext(h4b) + ext(h4b) + ext(h4b) - ext(h4c);
        corr_o = '0;
        if (order_i >= ORD_W'(1)) corr_o = corr_o + t1;
        if (order_i >= ORD_W'(2)) corr_o = corr_o + t2;
        if (order_i >= ORD_W'(3)) corr_o = corr_o + t3;
        if (order_i >= ORD_W'(4)) corr_o = corr_o + t4;
    end

    // Shift carry history; cleared by reset, sync or load.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            h2  <= 1'b0;
            h3a <= 1'b0;
            h3b <= 1'b0;
            h4a <= 1'b0;
            h4b <= 1'b0;
            h4c <= 1'b0;
        end else begin
            h2  <= carry_i[1];
            h3a <= carry_i[2];
            h3b <= h3a;
            h4a <= carry_i[3];
            h4b <= h4a;
            h4c <= h4b;
        end
    end
endmodule

// File: rtl/mash_divctl.sv
// Top of the programmable-modulus cascaded sigma-delta divide controller.
// Chains MAX_ORDER accumulator stages combinationally within a cycle,
// shapes their carries and registers integer + correction on div_o.
// Assumes the consumer samples div_o once per reference clock.
module mash_divctl
    import mash_pkg::*;
#(
    parameter int INT_W  = 19,
    parameter int FRAC_W = 32,
    parameter int ORD_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [INT_W-1:0]  int_i,
    input  logic [FRAC_W-1:0] num_i,
    input  logic [FRAC_W-1:0] den_i,
    input  logic [ORD_W-1:0]  order_i,
    input  logic              sync_i,
    input  logic              phase_i,
    input  logic [FRAC_W-1:0] phase_ofs_i,
    output logic [INT_W:0]    div_o
);
    localparam int OUT_W = INT_W + 1;

    logic [INT_W-1:0]  int_q;
    logic [FRAC_W-1:0] num_q;
    logic [FRAC_W-1:0] den_q;
    logic [ORD_W-1:0]  order_q;
    logic              clr;

    logic [MAX_ORDER-1:0][FRAC_W-1:0] stg_in;
    logic [MAX_ORDER-1:0][FRAC_W-1:0] stg_res;
    logic [MAX_ORDER-1:0][FRAC_W-1:0] stg_acc;
    logic [MAX_ORDER-1:0]             stg_carry;
    corr_t                            corr;
    logic [OUT_W:0]                   sum_w;

    assign clr = load_i | sync_i;

    mash_cfg_reg #(
        .INT_W (INT_W),
        .FRAC_W(FRAC_W),
        .ORD_W (ORD_W)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .int_i  (int_i),
        .num_i  (num_i),
        .den_i  (den_i),
        .order_i(order_i),
        .int_q  (int_q),
        .num_q  (num_q),
        .den_q  (den_q),
        .order_q(order_q)
    );

    for (genvar k = 0; k < MAX_ORDER; k++) begin : g_stage
        logic ofs_en;
        if (k == 0) begin : g_head
            assign stg_in[k] = num_q;
            assign ofs_en    = phase_i & ~clr;
        end else begin : g_tail
            assign stg_in[k] = stg_res[k-1];
            assign ofs_en    = 1'b0;
        end

        mash_acc_stage #(
            .FRAC_W(FRAC_W)
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (clr),
            .en_i    (order_q > ORD_W'(k)),
            .den_i   (den_q),
            .in_i    (stg_in[k]),
            .ofs_en_i(ofs_en),
            .ofs_i   (phase_ofs_i),
            .res_o   (stg_res[k]),
            .carry_o (stg_carry[k]),
            .acc_o   (stg_acc[k])
        );
    end

    mash_noise_shaper #(
        .ORD_W(ORD_W)
    ) u_shaper (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .order_i(order_q),
        .carry_i(stg_carry),
        .corr_o (corr)
    );

    // Add the sign-extended correction to the held integer value.
    always_comb begin
        sum_w = {2'b00, int_q} + {{(OUT_W + 1 - CORR_W){corr[CORR_W-1]}}, corr};
    end

    // Output register: integer alone on sync/load, shaped value otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_o <= '0;
        end else if (clr) begin
            div_o <= {1'b0, int_q};
        end else begin
            div_o <= OUT_W'(sum_w);
        end
    end
endmodule

// File: rtl/mash_divctl_chk.sv
// Assertion checker for mash_divctl, attached by bind below.
// Observes ports plus the held configuration and stage residues.
module mash_divctl_chk
    import mash_pkg::*;
#(
    parameter int INT_W  = 19,
    parameter int FRAC_W = 32,
    parameter int ORD_W  = 3
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             load_i,
    input logic                             sync_i,
    input logic [INT_W:0]                   div_o,
    input logic [INT_W-1:0]                 int_q,
    input logic [FRAC_W-1:0]                num_q,
    input logic [FRAC_W-1:0]                den_q,
    input logic [ORD_W-1:0]                 order_q,
    input logic [MAX_ORDER-1:0][FRAC_W-1:0] acc_i
);
    // R1: output is zero just after reset release
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> div_o == '0);

    // R2: stored denominator nonzero, numerator below it, order in range
    a_r2_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        den_q != '0);
    a_r2_num_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        num_q < den_q);
    a_r2_order_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        order_q <= ORD_W'(MAX_ORDER));

    // R3: integer mode passes the integer straight through
    a_r3_int_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $past(order_q) == '0 |-> div_o == {1'b0, $past(int_q)});

    // R4: every residue stays below the modulus
    for (genvar k = 0; k < MAX_ORDER; k++) begin : g_res
        a_r4_residue_below_den: assert property (@(posedge clk) disable iff (!rst_n)
            acc_i[k] < den_q);
    end

    // R6: correction swing bounded to -7..+8
    a_r6_corr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(div_o) - int'($past(int_q)) <= 8) &&
        (int'(div_o) - int'($past(int_q)) >= -7));

    // R7: sync or load leaves all residues at zero
    a_r7_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync_i || load_i) |-> acc_i == '0);
endmodule

bind mash_divctl mash_divctl_chk #(
    .INT_W (INT_W),
    .FRAC_W(FRAC_W),
    .ORD_W (ORD_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .sync_i (sync_i),
    .div_o  (div_o),
    .int_q  (int_q),
    .num_q  (num_q),
    .den_q  (den_q),
    .order_q(order_q),
    .acc_i  (stg_acc)
);

// File: tb/mash_divctl_tb.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps small moduli at every order against an
// arithmetic model, plus directed clamp, sync, phase and wide-range cases.
module mash_divctl_tb;
    localparam int INT_W  = 19;
    localparam int FRAC_W = 32;
    localparam int ORD_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_i = 1'b0;
    logic [INT_W-1:0]  int_i = '0;
    logic [FRAC_W-1:0] num_i = '0;
    logic [FRAC_W-1:0] den_i = '0;
    logic [ORD_W-1:0]  order_i = '0;
    logic              sync_i = 1'b0;
    logic              phase_i = 1'b0;
    logic [FRAC_W-1:0] phase_ofs_i = '0;
    logic [INT_W:0]    div_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    longint m_acc [4];
    longint m_h2, m_h3a, m_h3b, m_h4a, m_h4b, m_h4c;
    longint m_int, m_num, m_den, m_ord, m_out;

    always #2 clk = ~clk;

    mash_divctl #(.INT_W(INT_W), .FRAC_W(FRAC_W), .ORD_W(ORD_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .int_i(int_i),
        .num_i(num_i), .den_i(den_i), .order_i(order_i), .sync_i(sync_i),
        .phase_i(phase_i), .phase_ofs_i(phase_ofs_i), .div_o(div_o)
    );

    task automatic clear_model();
        for (int k = 0; k < 4; k++) m_acc[k] = 0;
        m_h2 = 0; m_h3a = 0; m_h3b = 0; m_h4a = 0; m_h4b = 0; m_h4c = 0;
    endtask

    // Model of one clock edge, written from the requirements.
    task automatic model_step(bit ld, bit sy, bit ph, longint ofs,
                              longint li, longint ln, longint lden, longint lo);
        longint c [4];
        longint inp, a, o, corr;
        if (ld || sy) begin
            m_out = m_int;
            clear_model();
            if (ld) begin
                m_den = (lden == 0) ? 1 : lden;
                m_num = (ln >= m_den) ? m_den - 1 : ln;
                m_int = li;
                m_ord = (lo > 4) ? 4 : lo;
            end
            return;
        end
        inp = m_num;
        for (int k = 0; k < 4; k++) begin
            if (k < m_ord) begin
                a = m_acc[k];
                if (k == 0 && ph) begin
                    o = (ofs >= m_den) ? m_den - 1 : ofs;
                    a = a + o;
                    if (a >= m_den) a = a - m_den;
                end
                a = a + inp;
                if (a >= m_den) begin a = a - m_den; c[k] = 1; end
                else c[k] = 0;
                m_acc[k] = a;
                inp = a;
            end else begin
                m_acc[k] = 0;
                c[k] = 0;
            end
        end
        corr = 0;
        if (m_ord >= 1) corr += c[0];
        if (m_ord >= 2) corr += c[1] - m_h2;
        if (m_ord >= 3) corr += c[2] - 2*m_h3a + m_h3b;
        if (m_ord >= 4) corr += c[3] - 3*m_h4a + 3*m_h4b - m_h4c;
        m_h2 = c[1];
        m_h3b = m_h3a; m_h3a = c[2];
        m_h4c = m_h4b; m_h4b = m_h4a; m_h4a = c[3];
        m_out = m_int + corr;
    endtask

    task automatic check(string tag, longint act, longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive strobes for one edge, step the model, compare at the next negedge.
    task automatic tick(bit ld, bit sy, bit ph, longint ofs, string tag);
        load_i = ld; sync_i = sy; phase_i = ph; phase_ofs_i = ofs[31:0];
        model_step(ld, sy, ph, ofs, longint'(int_i), longint'(num_i),
                   longint'(den_i), longint'(order_i));
        @(posedge clk);
        @(negedge clk);
        load_i = 0; sync_i = 0; phase_i = 0;
        check(tag, longint'(div_o), m_out);
    endtask

    task automatic do_load(longint iv, longint nv, longint dv, longint ov, string tag);
        int_i = iv[INT_W-1:0]; num_i = nv[31:0]; den_i = dv[31:0]; order_i = ov[2:0];
        tick(1, 0, 0, 0, tag);
    endtask

    // R9: sum corrections over one modulus window right after a load.
    task automatic window_check(string tag);
        longint s, lo_b, hi_b;
        s = 0;
        for (longint i = 0; i < m_den; i++) begin
            tick(0, 0, 0, 0, tag);
            s += longint'(div_o) - m_int;
        end
        lo_b = (m_ord >= 2) ? m_num - 3 : m_num;
        hi_b = (m_ord >= 2) ? m_num + 4 : m_num;
        if (m_ord == 0) begin lo_b = 0; hi_b = 0; end
        vectors++;
        if (s < lo_b || s > hi_b) begin
            miscompares++;
            $display("FAIL R9: window sum %0d expected %0d..%0d", s, lo_b, hi_b);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        longint dens [8] = '{1, 2, 3, 5, 7, 8, 13, 16};
        longint rec [24];
        longint mn, mx, d;

        m_int = 0; m_num = 0; m_den = 1; m_ord = 0; m_out = 0;
        clear_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", longint'(div_o), 0);
        // R1: pins without load keep the reset configuration (output 0)
        num_i = 5; den_i = 9; order_i = 2; int_i = 77;
        tick(0, 0, 0, 0, "R1");
        tick(0, 0, 0, 0, "R1");

        // R3/R4/R5/R9: sweep every numerator for small moduli at all orders
        for (int ord = 0; ord <= 4; ord++) begin
            foreach (dens[di]) begin
                for (longint n = 0; n < dens[di]; n++) begin
                    do_load(28 + (n * 37) % 1000, n, dens[di], ord, "R2");
                    window_check(ord == 0 ? "R3" : "R5");
                    for (longint i = 0; i < dens[di] + 4; i++)
                        tick(0, 0, 0, 0, ord == 0 ? "R3" : "R4");
                end
            end
        end

        // R2: numerator clamp, zero denominator, order clamp, pins ignored
        do_load(100, 20, 7, 1, "R2");
        window_check("R2");
        do_load(50, 3, 0, 2, "R2");
        repeat (4) tick(0, 0, 0, 0, "R2");
        do_load(60, 5, 13, 7, "R2");
        repeat (30) tick(0, 0, 0, 0, "R2");
        num_i = 1; den_i = 2; order_i = 0; int_i = 999;
        repeat (20) tick(0, 0, 0, 0, "R2");

        // R3: integer mode ignores numerator and phase strobe
        do_load(300, 4, 9, 0, "R3");
        tick(0, 0, 1, 5, "R3");
        repeat (5) tick(0, 0, 0, 0, "R3");

        // R6: widest modulus and extreme integer at order 4
        do_load(524287, 64'hFFFF_FFFE, 64'hFFFF_FFFF, 4, "R6");
        mn = 0; mx = 0;
        for (int i = 0; i < 300; i++) begin
            tick(0, 0, 0, 0, "R6");
            d = longint'(div_o) - m_int;
            if (d < mn) mn = d;
            if (d > mx) mx = d;
        end
        check("R6", (mn >= -7 && mx <= 8) ? 1 : 0, 1);
        do_load(28, 1, 64'hFFFF_FFFF, 4, "R6");
        repeat (100) tick(0, 0, 0, 0, "R6");
        do_load(1000, 64'h8000_0001, 64'hFFFF_FFFF, 3, "R6");
        repeat (100) tick(0, 0, 0, 0, "R6");

        // R7: sync replays the identical sequence
        do_load(40, 5, 13, 3, "R7");
        repeat (10) tick(0, 0, 0, 0, "R7");
        tick(0, 1, 0, 0, "R7");
        for (int i = 0; i < 24; i++) begin
            tick(0, 0, 0, 0, "R7");
            rec[i] = longint'(div_o);
        end
        tick(0, 1, 0, 0, "R7");
        for (int i = 0; i < 24; i++) begin
            tick(0, 0, 0, 0, "R7");
            check("R7", longint'(div_o), rec[i]);
        end

        // R8: phase offset, clamped offset, strobe with sync, higher order
        do_load(30, 3, 8, 1, "R8");
        repeat (3) tick(0, 0, 0, 0, "R8");
        tick(0, 0, 1, 5, "R8");
        repeat (10) tick(0, 0, 0, 0, "R8");
        tick(0, 0, 1, 100, "R8");
        repeat (10) tick(0, 0, 0, 0, "R8");
        tick(0, 1, 1, 6, "R8");
        repeat (10) tick(0, 0, 0, 0, "R8");
        do_load(45, 7, 11, 4, "R8");
        repeat (5) tick(0, 0, 0, 0, "R8");
        tick(0, 0, 1, 9, "R8");
        tick(0, 0, 1, 3, "R8");
        repeat (20) tick(0, 0, 0, 0, "R8");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule